// File: doc/BRIEF.md
# Synthesizer Programming Front End with Initialization Reset

This block takes a control word for a frequency synthesizer over a serial input and commits it with a load strobe. The two lowest bits of the committed word address one of four destinations: the reference-divider latch, the N-divider latch, the function latch, or the initialization entry. The initialization entry writes the function latch and also starts a realignment sequence. The remaining upper bits form the payload that is stored.

From the stored state, the block drives several control outputs. It produces a one-cycle reset pulse for the reference, N and timeout counters. It drives a three-state request for the charge pump, a counter-hold level and a power-down output. The power-down output reacts at once to the chip-enable pin. It also follows a synchronous power-down request, which is armed by an initialization with the right mode bits.

An initialization load fires the reset pulse. The first N-divider load after it fires the pulse once more. Any later N loads leave the counters alone until a new initialization arrives.

Top module: `synth_prog_front`

## Requirements
- R1: While `sh_en` is high, each rising `clk` edge shifts `sdata` into the word register. The most significant bit arrives first.
- R2: On the first `clk` edge where `load` is seen high after being low, the word's bits [1:0] pick the target: 00 reference, 01 N, 10 function, 11 initialization. Only that latch takes bits [W-1:2]. An initialization load writes the function latch.
- R3: An initialization load raises `cnt_rst_pulse` on the cycle after the load edge.
- R4: The first N load after an initialization raises `cnt_rst_pulse`. Later N loads do not, until the next initialization. Loads to reference and function do not affect this. The pulse lasts exactly one cycle.
- R5: While `cnt_rst_pulse` is high, `cp_tristate` is high.
- R6: An initialization load sets synchronous power-down if `ce` is high and word bit 3 (PD1) is 1 while word bit 4 (PD2) is 0. Any function or initialization load whose bits 3/4 are not 1/0 clears synchronous power-down.
- R7: Function bit 2 (counter reset, word bit 2) drives `cnt_hold` and forces `cp_tristate`. On its own it never raises `pwr_dn`. If it is 1 in an initialization word, the hold still applies.
- R8: `pwr_dn` is high at once while `ce` is low, with no clock edge needed. Latch contents are kept through power-down.
- R9: After reset, all latches read zero, the pulse and hold are low, and `pwr_dn` equals the inverse of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; low forces power-down |
| sdata | input | 1 | Serial data, MSB first |
| sh_en | input | 1 | Shift enable |
| load | input | 1 | Commit strobe, edge detected |
| ref_word | output | WORD_W-2 | Reference-divider latch |
| n_word | output | WORD_W-2 | N-divider latch |
| func_word | output | WORD_W-2 | Function latch |
| cnt_rst_pulse | output | 1 | One-cycle counter reset |
| cp_tristate | output | 1 | Charge-pump three-state request |
| cnt_hold | output | 1 | Counters held at load point |
| pwr_dn | output | 1 | Power-down |

## Verification
On every cycle, the assertions check several fixed relations. An initialization commit is followed by a pulse, and the pulse never lasts beyond one cycle. The pulse and the counter hold both imply three-state, and chip enable low implies power-down. Other behaviours need the bench's scenarios to show them. These are the once-only re-arm after initialization across interleaved reference and function loads, and the routing of each payload to exactly one latch. They also include setting and clearing synchronous power-down under the chip-enable level, and the fact that latch contents survive chip-enable cycling. The bench sweeps every word of an 8-bit configuration and compares each result against a model of these rules.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  typedef enum logic [1:0] {
    SEL_REF  = 2'b00,
    SEL_N    = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } latch_sel_e;

  // positions inside the stored payload (word bit = payload bit + 2)
  localparam int unsigned FB_HOLD = 0;
  localparam int unsigned FB_PD1  = 1;
  localparam int unsigned FB_PD2  = 2;
  localparam int unsigned ADDR_W  = 2;
endpackage

// File: rtl/sp_shift_in.sv
module sp_shift_in #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sh_en,
  input  logic              sdata,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (sh_en) sr_d = {sr_q[WORD_W-2:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (sh_en) sr_q <= sr_d;
  end

  assign word = sr_q;
endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank
  import synth_prog_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned PW = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [PW-1:0]     ref_q,
  output logic [PW-1:0]     n_q,
  output logic [PW-1:0]     func_q,
  output logic              st_n,
  output logic              st_init,
  output logic              st_func_any,
  output logic [PW-1:0]     payload
);
  logic       ld_q;
  logic       commit;
  latch_sel_e sel;
  logic [PW-1:0] ref_d, n_d, func_d;

  assign commit  = load & ~ld_q;
  assign sel     = latch_sel_e'(word[ADDR_W-1:0]);
  assign payload = word[WORD_W-1:ADDR_W];

  assign st_n        = commit && (sel == SEL_N);
  assign st_init     = commit && (sel == SEL_INIT);
  assign st_func_any = commit && ((sel == SEL_FUNC) || (sel == SEL_INIT));

  always_comb begin
    ref_d  = ref_q;
    n_d    = n_q;
    func_d = func_q;
    if (commit) begin
      unique case (sel)
        SEL_REF:  ref_d  = payload;
        SEL_N:    n_d    = payload;
        SEL_FUNC: func_d = payload;
        SEL_INIT: func_d = payload;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      ref_q  <= '0;
      n_q    <= '0;
      func_q <= '0;
    end else begin
      ld_q <= load;
      if (commit) begin
        ref_q  <= ref_d;
        n_q    <= n_d;
        func_q <= func_d;
      end
    end
  end
endmodule

// File: rtl/sp_realign_seq.sv
module sp_realign_seq
  import synth_prog_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned PW = WORD_W - ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          st_n,
  input  logic          st_init,
  input  logic          st_func_any,
  input  logic [PW-1:0] payload,
  output logic          pulse,
  output logic          sync_pd
);
  logic armed_q, armed_d;
  logic pulse_d;
  logic sync_d;
  logic pd_req;

  assign pd_req = payload[FB_PD1] & ~payload[FB_PD2];

  always_comb begin
    pulse_d = st_init | (st_n & armed_q);
    armed_d = armed_q;
    if (st_init)   armed_d = 1'b1;
    else if (st_n) armed_d = 1'b0;
    sync_d = sync_pd;
    if (st_func_any && !pd_req)           sync_d = 1'b0;
    else if (st_init && pd_req && ce)     sync_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse   <= 1'b0;
      sync_pd <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse   <= pulse_d;
      sync_pd <= sync_d;
    end
  end
endmodule

// File: rtl/synth_prog_front.sv
module synth_prog_front
  import synth_prog_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned PW = WORD_W - ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          sdata,
  input  logic          sh_en,
  input  logic          load,
  output logic [PW-1:0] ref_word,
  output logic [PW-1:0] n_word,
  output logic [PW-1:0] func_word,
  output logic          cnt_rst_pulse,
  output logic          cp_tristate,
  output logic          cnt_hold,
  output logic          pwr_dn
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [WORD_W-1:0] word;
  logic              st_n, st_init, st_func_any;
  logic [PW-1:0]     payload;
  logic              sync_pd;

  sp_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .sh_en(sh_en), .sdata(sdata), .word(word)
  );

  sp_latch_bank #(.WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .load(load), .word(word),
    .ref_q(ref_word), .n_q(n_word), .func_q(func_word),
    .st_n(st_n), .st_init(st_init), .st_func_any(st_func_any),
    .payload(payload)
  );

  sp_realign_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .ce(ce),
    .st_n(st_n), .st_init(st_init), .st_func_any(st_func_any),
    .payload(payload), .pulse(cnt_rst_pulse), .sync_pd(sync_pd)
  );

  assign cnt_hold    = func_word[FB_HOLD];
  assign cp_tristate = cnt_rst_pulse | cnt_hold;
  assign pwr_dn      = ~ce | sync_pd;
endmodule

// File: rtl/synth_prog_front_chk.sv
module synth_prog_front_chk (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic st_init,
  input logic st_n,
  input logic cnt_rst_pulse,
  input logic cp_tristate,
  input logic cnt_hold,
  input logic pwr_dn
);
  p_init_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_init |=> cnt_rst_pulse);
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_pulse |=> !cnt_rst_pulse);
  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_rst_pulse) |-> $past(st_init || st_n));
  p_tri_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_pulse |-> cp_tristate);
  p_tri_on_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hold |-> cp_tristate);
  p_ce_low_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> pwr_dn);
endmodule

bind synth_prog_front synth_prog_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .st_init(st_init), .st_n(st_n),
  .cnt_rst_pulse(cnt_rst_pulse), .cp_tristate(cp_tristate),
  .cnt_hold(cnt_hold), .pwr_dn(pwr_dn)
);

// File: tb/synth_prog_front_tb.sv
module synth_prog_front_tb;
  localparam int W  = 8;
  localparam int PW = W - 2;

  logic clk, rst_n, ce, sdata, sh_en, load;
  logic [PW-1:0] ref_word, n_word, func_word;
  logic cnt_rst_pulse, cp_tristate, cnt_hold, pwr_dn;

  int total = 0;
  int bad = 0;

  logic [PW-1:0] e_ref, e_n, e_func;
  logic e_armed, e_sync;

  synth_prog_front #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sdata(sdata), .sh_en(sh_en),
    .load(load), .ref_word(ref_word), .n_word(n_word), .func_word(func_word),
    .cnt_rst_pulse(cnt_rst_pulse), .cp_tristate(cp_tristate),
    .cnt_hold(cnt_hold), .pwr_dn(pwr_dn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " R2 ref"}, 32'(ref_word), 32'(e_ref));
    check({tag, " R2 n"}, 32'(n_word), 32'(e_n));
    check({tag, " R2 func"}, 32'(func_word), 32'(e_func));
    check({tag, " R7 hold"}, 32'(cnt_hold), 32'(e_func[0]));
    check({tag, " R8 pwr_dn"}, 32'(pwr_dn), 32'(!ce || e_sync));
  endtask

  // shift a word MSB first, commit it, and check both cycles around the pulse
  task automatic send(input logic [W-1:0] w);
    logic exp_pulse;
    logic req;
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      sdata = w[i];
      sh_en = 1'b1;
    end
    @(negedge clk);
    sh_en = 1'b0;
    load  = 1'b1;
    // model
    req = w[3] && !w[4];
    exp_pulse = (w[1:0] == 2'b11) || (w[1:0] == 2'b01 && e_armed);
    case (w[1:0])
      2'b00: e_ref = w[W-1:2];
      2'b01: begin e_n = w[W-1:2]; e_armed = 1'b0; end
      2'b10: e_func = w[W-1:2];
      default: begin e_func = w[W-1:2]; e_armed = 1'b1; end
    endcase
    if (w[1] && !req) e_sync = 1'b0;
    else if (w[1:0] == 2'b11 && req && ce) e_sync = 1'b1;
    @(posedge clk);
    #1;
    check("R3/R4 pulse", 32'(cnt_rst_pulse), 32'(exp_pulse));
    check("R5 tristate", 32'(cp_tristate), 32'(exp_pulse || e_func[0]));
    check_state("R6");
    @(negedge clk);
    load = 1'b0;
    @(posedge clk);
    #1;
    check("R4 one cycle", 32'(cnt_rst_pulse), 32'd0);
    check("R7 tristate", 32'(cp_tristate), 32'(e_func[0]));
  endtask

  initial begin
    rst_n = 1'b0; ce = 1'b1; sdata = 1'b0; sh_en = 1'b0; load = 1'b0;
    e_ref = '0; e_n = '0; e_func = '0; e_armed = 1'b0; e_sync = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 pulse", 32'(cnt_rst_pulse), 32'd0);
    check_state("R9");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1/R2/R3/R4/R6: full sweep of all words with chip enable high
    for (int w = 0; w < (1 << W); w++) send(W'(w));

    // R4: init, then several N loads; only the first N pulses
    send({6'h00, 2'b11});
    send({6'h15, 2'b00});
    send({6'h2A, 2'b10});
    send({6'h11, 2'b01});
    send({6'h22, 2'b01});
    send({6'h33, 2'b01});

    // R8: chip enable low forces power-down immediately, latches kept
    send({6'h00, 2'b10});
    @(negedge clk);
    ce = 1'b0;
    #1;
    check("R8 async pd", 32'(pwr_dn), 32'd1);
    check_state("R8 held");
    // R6: init requesting sync pd while ce low does not set it
    send({6'b000010, 2'b11});
    @(negedge clk);
    ce = 1'b1;
    #1;
    check("R6 no set with ce low", 32'(pwr_dn), 32'd0);
    check_state("R8 restore");

    // R6 set, then clear by function load
    send({6'b000010, 2'b11});
    check("R6 set", 32'(pwr_dn), 32'd1);
    send({6'b000110, 2'b10});
    check("R6 clear", 32'(pwr_dn), 32'd0);

    // R7: hold bit in init word; hold wins, no power-down from hold
    send({6'b000001, 2'b11});
    check("R7 hold in init", 32'(cnt_hold), 32'd1);
    check("R7 no pd from hold", 32'(pwr_dn), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule